// File: doc/BRIEF.md
# Debug Instruction and Data Transfer Chains

This block holds the two debug data registers through which an external debugger drives a halted processor core. An instruction register chain carries an opcode for the core to run. A data register chain moves one word at a time between the debugger and the core, in either direction. The block sits behind a debug test access port. It takes the port's capture, shift and update strobes, the serial input bit, a Run-Test/Idle indication, and the currently loaded instruction and chain number. It returns one serial output bit.

Toward the core it presents an issue strobe with the latched opcode. It also offers a write word with a valid flag that the core consumes. The core returns a completion level and can deposit a read word. A one-cycle issue pulse is produced on each entry into Run-Test/Idle, provided the instruction chain or the data chain is selected at that moment. A debugger can therefore load an opcode, stop in Pause-DR, load a data word, and only then let the instruction run.

The data chain carries two status bits after the word. Ready tells whether the current transfer can complete. nRetry tells the debugger whether the previous transfer was dropped and must be repeated.

Top module: `dbg_xfer_chains`

## Requirements
- R1: After reset, core_issue, core_wvalid and tdo are 0 and core_opcode and core_wdata are 0.
- R2: The instruction chain is 33 bits long: opcode bits 0 to 31 shift out first, least significant first, then one bit holding core_done as sampled at capture. Capture loads the current core_opcode. Update copies the 32 shifted opcode bits to core_opcode, and core_opcode changes at no other time.
- R3: Chain selection uses instruction codes EXTEST=5'h00, INTEST=5'h0C and ITRSEL=5'h1D. The instruction chain is selected by ITRSEL under any chain number, or by EXTEST or INTEST with chain number 4. The data chain is selected by EXTEST or INTEST with chain number 5. With no chain selected, tdo is 0 and an update has no effect.
- R4: The data chain is 34 bits long: 32 data bits least significant first, then Ready at bit 32, then nRetry at bit 33.
- R5: Under EXTEST, capture loads the word currently offered to the core and sets Ready to the inverse of core_wvalid. An update that follows a capture with Ready 1 drives the shifted word onto core_wdata and sets core_wvalid. A core_wr_take pulse clears core_wvalid.
- R6: Under EXTEST, a word shifted after a capture with Ready 0 is discarded: core_wdata and core_wvalid do not change.
- R7: A core_rd_put pulse stores core_rdata and marks it valid. Under INTEST, capture loads the stored word and sets Ready to its valid flag. An update that follows a capture with Ready 1 clears the valid flag.
- R8: When the controller enters Run-Test/Idle with either chain selected, core_issue pulses high for one cycle, starting the cycle after entry, with core_opcode holding the last updated opcode.
- R9: Staying in Run-Test/Idle produces no further pulse. Leaving and re-entering produces a new one.
- R10: Entering Run-Test/Idle with neither chain selected produces no pulse.
- R11: nRetry captures 0 when the previous data chain update was discarded (write with Ready 0 or read with Ready 0). It captures 1 after a successful one and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_code | input | 5 | Instruction currently held by the debug port |
| chain_sel | input | 4 | Chain number currently selected |
| cap_dr | input | 1 | One-cycle capture strobe |
| shift_dr | input | 1 | Shift enable, one bit per cycle |
| upd_dr | input | 1 | One-cycle update strobe |
| run_idle | input | 1 | High while the controller is in Run-Test/Idle |
| tdi | input | 1 | Serial input bit |
| tdo | output | 1 | Serial output bit of the selected chain |
| core_issue | output | 1 | One-cycle pulse: run core_opcode |
| core_opcode | output | 32 | Latched opcode |
| core_done | input | 1 | Completion level from the core |
| core_wdata | output | 32 | Word offered to the core |
| core_wvalid | output | 1 | core_wdata holds an unconsumed word |
| core_wr_take | input | 1 | Core consumed core_wdata |
| core_rdata | input | 32 | Word produced by the core |
| core_rd_put | input | 1 | Store core_rdata as valid read data |

## Verification
The assertions assume that capture, shift and update strobes come one at a time, in capture-shift-update order, and that ir_code and chain_sel stay constant from capture to update. They also assume that the core neither deposits read data nor takes the write word between a capture and its update. The bench drives every scan as one task that holds the instruction and chain still throughout. It pulses core_rd_put and core_wr_take only between scans, so the stimulus stays inside those limits. It sweeps every instruction class against chain numbers 0 to 7 for issue behaviour, and walks the write and read paths through both the Ready and the retry outcomes.

// File: rtl/dbg_xfer_chains.sv
`timescale 1ns/1ps
module dbg_xfer_chains #(
  parameter int IR_W        = 5,
  parameter int CHAIN_W     = 4,
  parameter int WORD_W      = 32,
  parameter int CODE_EXTEST = 'h00,
  parameter int CODE_INTEST = 'h0C,
  parameter int CODE_ITRSEL = 'h1D,
  parameter int ITR_CHAIN   = 4,
  parameter int DTR_CHAIN   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   ir_code,
  input  logic [CHAIN_W-1:0] chain_sel,
  input  logic              cap_dr,
  input  logic              shift_dr,
  input  logic              upd_dr,
  input  logic              run_idle,
  input  logic              tdi,
  output logic              tdo,
  output logic              core_issue,
  output logic [WORD_W-1:0] core_opcode,
  input  logic              core_done,
  output logic [WORD_W-1:0] core_wdata,
  output logic              core_wvalid,
  input  logic              core_wr_take,
  input  logic [WORD_W-1:0] core_rdata,
  input  logic              core_rd_put
);
  localparam int ITR_LEN = WORD_W + 1;
  localparam int DTR_LEN = WORD_W + 2;

  logic [DTR_LEN-1:0] sr;
  logic [WORD_W-1:0]  rd_buf;
  logic               rd_valid, cap_ok, failed, idle_q;

  wire is_ext  = ir_code == IR_W'(CODE_EXTEST);
  wire is_int  = ir_code == IR_W'(CODE_INTEST);
  wire is_isel = ir_code == IR_W'(CODE_ITRSEL);
  wire itr_sel = is_isel | ((is_ext | is_int) & (chain_sel == CHAIN_W'(ITR_CHAIN)));
  wire dtr_sel = ~is_isel & (is_ext | is_int) & (chain_sel == CHAIN_W'(DTR_CHAIN));
  wire dtr_upd = upd_dr & dtr_sel;

  assign tdo = (itr_sel | dtr_sel) ? sr[0] : 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0;
    end else if (cap_dr) begin
      if (itr_sel)
        sr <= {1'b0, core_done, core_opcode};
      else if (dtr_sel)
        sr <= is_ext ? {~failed, ~core_wvalid, core_wdata} : {~failed, rd_valid, rd_buf};
      else
        sr <= '0;
    end else if (shift_dr) begin
      if (itr_sel)
        sr <= {1'b0, tdi, sr[ITR_LEN-1:1]};
      else if (dtr_sel)
        sr <= {tdi, sr[DTR_LEN-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cap_ok <= 1'b0;
    else if (cap_dr && dtr_sel)
      cap_ok <= is_ext ? ~core_wvalid : rd_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      failed <= 1'b0;
    else if (dtr_upd)
      failed <= ~cap_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      core_opcode <= '0;
    else if (upd_dr && itr_sel)
      core_opcode <= sr[WORD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_wdata  <= '0;
      core_wvalid <= 1'b0;
    end else if (dtr_upd && is_ext && cap_ok) begin
      core_wdata  <= sr[WORD_W-1:0];
      core_wvalid <= 1'b1;
    end else if (core_wr_take) begin
      core_wvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_buf   <= '0;
      rd_valid <= 1'b0;
    end else if (core_rd_put) begin
      rd_buf   <= core_rdata;
      rd_valid <= 1'b1;
    end else if (dtr_upd && is_int && cap_ok) begin
      rd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q     <= 1'b0;
      core_issue <= 1'b0;
    end else begin
      idle_q     <= run_idle;
      core_issue <= run_idle & ~idle_q & (itr_sel | dtr_sel);
    end
  end

  // R9: an issue never lasts longer than one cycle
  p_issue_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_issue |=> !core_issue);

  // R8: an issue only follows a cycle spent in Run-Test/Idle
  p_issue_in_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    core_issue |-> $past(run_idle));

  // R2: opcode only moves on an instruction chain update
  p_opcode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_dr && itr_sel) |=> $stable(core_opcode));

  // R6: a write arriving while the previous word is pending is dropped
  p_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dtr_upd && is_ext && core_wvalid && !core_wr_take) |=> core_wvalid && $stable(core_wdata));

  // R5: an accepted write raises the valid flag
  p_write_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dtr_upd && is_ext && cap_ok) |=> core_wvalid);

  // R7: a successful read releases the read word
  p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dtr_upd && is_int && cap_ok && !core_rd_put) |=> !rd_valid);
endmodule

// File: tb/tb_dbg_xfer_chains.sv
`timescale 1ns/1ps
module tb_dbg_xfer_chains;
  localparam logic [4:0] EXT = 5'h00, INT = 5'h0C, ISEL = 5'h1D, OTHER = 5'h03;

  logic clk = 0, rst_n = 0;
  logic [4:0] ir_code = ISEL;
  logic [3:0] chain_sel = 0;
  logic cap_dr = 0, shift_dr = 0, upd_dr = 0, run_idle = 0, tdi = 0;
  logic tdo, core_issue, core_wvalid;
  logic [31:0] core_opcode, core_wdata;
  logic core_done = 0, core_wr_take = 0, core_rd_put = 0;
  logic [31:0] core_rdata = 0;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dbg_xfer_chains dut (
    .clk(clk), .rst_n(rst_n), .ir_code(ir_code), .chain_sel(chain_sel),
    .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr), .run_idle(run_idle),
    .tdi(tdi), .tdo(tdo), .core_issue(core_issue), .core_opcode(core_opcode),
    .core_done(core_done), .core_wdata(core_wdata), .core_wvalid(core_wvalid),
    .core_wr_take(core_wr_take), .core_rdata(core_rdata), .core_rd_put(core_rd_put));

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic scan(input int len, input logic [33:0] din, output logic [33:0] dout);
    dout = '0;
    @(negedge clk) cap_dr = 1;
    @(negedge clk) cap_dr = 0;
    for (int i = 0; i < len; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      shift_dr = 1;
      @(negedge clk);
    end
    shift_dr = 0;
    upd_dr = 1;
    @(negedge clk) upd_dr = 0;
  endtask

  task automatic idle_visit(input int cycles, output int pulses, output logic [31:0] op);
    pulses = 0;
    op = 'x;
    @(negedge clk) run_idle = 1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (core_issue) begin pulses++; op = core_opcode; end
    end
    run_idle = 0;
    @(negedge clk);
    if (core_issue) pulses++;
    @(negedge clk);
  endtask

  task automatic pulse_take();
    @(negedge clk) core_wr_take = 1;
    @(negedge clk) core_wr_take = 0;
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [33:0] dout;
    logic [31:0] prev_op, op, got_op, last_w;
    int pulses;
    bit exp_issue;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(core_issue == 0 && core_wvalid == 0 && tdo == 0, "R1 reset flags", {core_issue, core_wvalid, tdo}, 0);
    check(core_opcode == 0 && core_wdata == 0, "R1 reset words", {core_opcode, core_wdata}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R3 instruction chain sweep through its three select paths
    prev_op = 0;
    for (int k = 0; k < 12; k++) begin
      op = 32'(k) * 32'h9E3779B1 + 32'h1;
      core_done = k[0];
      case (k % 3)
        0: begin ir_code = ISEL; chain_sel = 4'(k & 7); end
        1: begin ir_code = EXT;  chain_sel = 4; end
        default: begin ir_code = INT; chain_sel = 4; end
      endcase
      scan(33, {2'b00, op}, dout);
      check(dout[31:0] == prev_op, "R2 R3 opcode shifted out", dout[31:0], prev_op);
      check(dout[32] == k[0], "R2 completion flag", dout[32], k[0]);
      check(core_opcode == op, "R2 opcode updated", core_opcode, op);
      prev_op = op;
    end
    core_done = 0;

    // R8/R10 issue against every instruction class and chains 0..7
    for (int c = 0; c < 8; c++) begin
      for (int m = 0; m < 4; m++) begin
        ir_code = (m == 0) ? EXT : (m == 1) ? INT : (m == 2) ? ISEL : OTHER;
        chain_sel = 4'(c);
        exp_issue = (m == 2) || (m < 2 && (c == 4 || c == 5));
        idle_visit(3, pulses, got_op);
        check(pulses == int'(exp_issue), exp_issue ? "R8 issue on entry" : "R10 no issue unselected", pulses, exp_issue);
        if (exp_issue)
          check(got_op == prev_op, "R8 issued opcode", got_op, prev_op);
      end
    end

    // R9 long stay issues once; re-entry issues again
    ir_code = ISEL;
    idle_visit(8, pulses, got_op);
    check(pulses == 1, "R9 long stay single issue", pulses, 1);
    idle_visit(2, pulses, got_op);
    check(pulses == 1, "R9 re-entry issues again", pulses, 1);

    // R4/R5/R6/R11 write path
    ir_code = EXT; chain_sel = 5;
    scan(34, {2'b00, 32'hA5A5_0001}, dout);
    check(dout[32] == 1 && dout[33] == 1, "R4 R5 ready and nretry on empty", dout[33:32], 2'b11);
    check(core_wvalid && core_wdata == 32'hA5A5_0001, "R5 write delivered", core_wdata, 32'hA5A5_0001);
    scan(34, {2'b00, 32'h1234_5678}, dout);
    check(dout[31:0] == 32'hA5A5_0001, "R5 pending word captured", dout[31:0], 32'hA5A5_0001);
    check(dout[32] == 0 && dout[33] == 1, "R5 ready low when pending", dout[33:32], 2'b10);
    check(core_wdata == 32'hA5A5_0001 && core_wvalid, "R6 write discarded", core_wdata, 32'hA5A5_0001);
    scan(34, {2'b00, 32'h0BAD_F00D}, dout);
    check(dout[33] == 0, "R11 nretry after discard", dout[33], 0);
    pulse_take();
    check(core_wvalid == 0, "R5 take clears valid", core_wvalid, 0);
    last_w = 32'h0;
    for (int k = 0; k < 6; k++) begin
      op = 32'hC001_0000 + 32'(k * 7);
      scan(34, {2'b00, op}, dout);
      check(dout[32] == 1, "R5 ready after take", dout[32], 1);
      check(dout[33] == (k != 0), "R11 nretry after previous access", dout[33], k != 0);
      check(core_wdata == op && core_wvalid, "R5 write sweep", core_wdata, op);
      pulse_take();
    end
    last_w = core_wdata;

    // R7/R11 read path
    ir_code = INT;
    scan(34, 34'h0, dout);
    check(dout[32] == 0 && dout[33] == 1, "R7 ready low without data", dout[33:32], 2'b10);
    for (int k = 0; k < 4; k++) begin
      op = 32'h5EED_0000 ^ (32'(k) << 8);
      @(negedge clk) begin core_rdata = op; core_rd_put = 1; end
      @(negedge clk) core_rd_put = 0;
      scan(34, 34'h0, dout);
      check(dout[31:0] == op && dout[32] == 1, "R7 read word captured", dout[32:0], {1'b1, op});
      check(dout[33] == (k != 0), "R11 nretry on read", dout[33], k != 0);
    end
    scan(34, 34'h0, dout);
    check(dout[32] == 0, "R7 read valid cleared", dout[32], 0);

    // R3 unselected chain: tdo silent, no write
    ir_code = EXT; chain_sel = 6;
    scan(34, {2'b00, 32'hFFFF_FFFF}, dout);
    check(dout == 0, "R3 tdo zero unselected", dout, 0);
    check(core_wvalid == 0 && core_wdata == last_w, "R3 update ignored", core_wdata, last_w);

    // R8 load opcode, pause, load data, then run
    ir_code = ISEL; chain_sel = 5;
    scan(33, {2'b00, 32'hE000_0042}, dout);
    ir_code = EXT; chain_sel = 5;
    scan(34, {2'b00, 32'h0000_7777}, dout);
    idle_visit(2, pulses, got_op);
    check(pulses == 1 && got_op == 32'hE000_0042, "R8 issue after data load", got_op, 32'hE000_0042);
    check(core_wvalid && core_wdata == 32'h0000_7777, "R8 data ready before run", core_wdata, 32'h7777);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule